// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between an internal valid/ready request bus and an external 32K x 8 asynchronous static RAM. It accepts one read or one write at a time and plays each one out on the memory pins. It drives active-low chip select, write strobe and output enable, a registered 15-bit address, and an 8-bit data path. The data path is split into a driven value, a drive enable and the returned value. A pad ring or the parent joins these into the bidirectional bus.

All memory timing limits are parameters given in nanoseconds, with defaults chosen by a speed-grade parameter. The clock period is also a parameter, given in picoseconds. Every limit is turned into a whole number of clocks by rounding up, so each minimum is met at any clock rate.

Writes are controlled by the write strobe, and chip select falls in the same cycle. Before the controller drives write data, it waits out the memory's output-release time after any read. Read data is captured one clock after the counted access time. It is returned with a single-cycle response pulse.

Top module: `asram_cycle_ctrl`

## Requirements
- R1: When reset is released, chip select, write strobe and output enable are all high, the data drive enable is low, req_ready is high and rsp_valid is low.
- R2: A request is taken only while req_ready is high, and req_ready is high only in the idle state. On the cycle after a request is taken, req_ready is low. While req_ready is high, chip select is high.
- R3: A read holds chip select and output enable low and the write strobe high for N_RD + 1 cycles. N_RD is the larger of ceil(address access / clock) and ceil(output-enable access / clock), which is 14 at the defaults. The data on the bus at the last edge is returned on rsp_rdata with rsp_valid high in the cycle right after output enable rises.
- R4: On a write, chip select and the write strobe fall on the same edge, so the strobe is never later than chip select. Both stay low for exactly N_PULSE cycles, where N_PULSE is the largest of the clock counts for write pulse width, address-to-strobe-rise and data setup (13 at the defaults). Both rise together, and output enable stays high throughout.
- R5: While chip select is low, the address does not change. On a write, the address is already valid one cycle before the strobes fall.
- R6: Write data is driven in every cycle of the write pulse. Drive is released on the same edge at which the strobes rise.
- R7: Between the falling write strobe of one write and the next falling edge of chip select there are at least ceil(write cycle / clock) cycles, which is 14 at the defaults.
- R8: The data drive enable is never high while output enable is low. It rises no sooner than ceil(output disable / clock) cycles after output enable last rose, which is 5 at the defaults.
- R9: Each read produces exactly one rsp_valid pulse, which lasts one cycle. A write produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | DW | Read data |
| sram_addr | output | AW | Address to the memory |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | DW | Data to drive onto the bus |
| sram_dq_oe | output | 1 | Bus drive enable |
| sram_dq_in | input | DW | Data seen on the bus |

## Verification
The hardest case to reach is a write that starts while the memory may still be releasing the bus after a read. Output enable must rise and the request for a write must already be waiting, so that the turnaround wait is the only thing holding back the data drive. The bench issues writes right behind reads, so the new request is presented on the cycle the controller returns to idle. A behavioural memory model measures the gap in clocks from the rise of output enable to the start of data drive. The same model drives deliberately wrong data until the access time has passed, so a sample taken too early shows up as a data mismatch.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_W_TURN,
      ST_W_PULSE,
      ST_W_REC,
      ST_R_ACC,
      ST_R_SAMP
   } seq_state_t;

   // nanoseconds to whole clocks, rounded up, never below one
   function automatic int ns_to_clk(input int ns, input int clk_ps);
      int q;
      q = (ns * 1000 + clk_ps - 1) / clk_ps;
      if (q < 1) q = 1;
      return q;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_down_cnt.sv
module asram_down_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt <= '0;
      else if (load)            cnt <= load_val;
      else if (cnt != '0)       cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int AW      = 15,
   parameter int DW      = 8,
   parameter int CW      = 4,
   parameter int N_RD    = 14,
   parameter int N_PULSE = 13,
   parameter int N_REC   = 1,
   parameter int N_DIS   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ready,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   input  logic          phase_done,
   output logic          phase_load,
   output logic [CW-1:0] phase_val,
   input  logic          turn_done,
   output logic          turn_load,
   output logic [CW-1:0] turn_val,
   output logic [AW-1:0] sram_addr,
   output logic          sram_cs_n,
   output logic          sram_we_n,
   output logic          sram_oe_n,
   output logic [DW-1:0] sram_dq_out,
   output logic          sram_dq_oe,
   input  logic [DW-1:0] sram_dq_in
);

   seq_state_t    st, st_nx;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic [DW-1:0] rdata_q;
   logic          rsp_q;

   always_comb begin
      st_nx      = st;
      phase_load = 1'b0;
      phase_val  = '0;
      turn_load  = 1'b0;
      turn_val   = '0;
      unique case (st)
         ST_IDLE: begin
            if (req_valid) begin
               if (req_write) begin
                  st_nx = ST_W_TURN;
               end else begin
                  st_nx      = ST_R_ACC;
                  phase_load = 1'b1;
                  phase_val  = CW'(N_RD - 1);
               end
            end
         end
         ST_W_TURN: begin
            if (turn_done) begin
               st_nx      = ST_W_PULSE;
               phase_load = 1'b1;
               phase_val  = CW'(N_PULSE - 1);
            end
         end
         ST_W_PULSE: begin
            if (phase_done) begin
               st_nx      = ST_W_REC;
               phase_load = 1'b1;
               phase_val  = CW'(N_REC - 1);
            end
         end
         ST_W_REC:  if (phase_done) st_nx = ST_IDLE;
         ST_R_ACC:  if (phase_done) st_nx = ST_R_SAMP;
         ST_R_SAMP: begin
            st_nx     = ST_IDLE;
            turn_load = 1'b1;
            turn_val  = CW'(N_DIS - 1);
         end
         default:   st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         rsp_q   <= 1'b0;
      end else begin
         st    <= st_nx;
         rsp_q <= (st == ST_R_SAMP);
         if (st == ST_IDLE && req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (st == ST_R_SAMP) rdata_q <= sram_dq_in;
      end
   end

   assign req_ready   = (st == ST_IDLE);
   assign rsp_valid   = rsp_q;
   assign rsp_rdata   = rdata_q;
   assign sram_addr   = addr_q;
   assign sram_cs_n   = !(st == ST_W_PULSE || st == ST_R_ACC || st == ST_R_SAMP);
   assign sram_we_n   = !(st == ST_W_PULSE);
   assign sram_oe_n   = !(st == ST_R_ACC || st == ST_R_SAMP);
   assign sram_dq_oe  = (st == ST_W_PULSE);
   assign sram_dq_out = wdata_q;

   // R8
   drive_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> sram_oe_n);

   // R4
   we_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> $fell(sram_cs_n));

   // R5
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

   // R2
   idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (sram_cs_n && sram_we_n && sram_oe_n));

   // R9
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R6
   data_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> sram_dq_oe);

endmodule

// File: rtl/asram_cycle_ctrl.sv
module asram_cycle_ctrl
   import asram_pkg::*;
#(
   parameter int AW          = 15,
   parameter int DW          = 8,
   parameter int CLK_PS      = 5000,
   parameter int SPEED_GRADE = 0,
   parameter int T_ACC_NS    = (SPEED_GRADE == 0) ? 70 : 85,
   parameter int T_OEACC_NS  = (SPEED_GRADE == 0) ? 35 : 45,
   parameter int T_WP_NS     = (SPEED_GRADE == 0) ? 55 : 60,
   parameter int T_AW_NS     = (SPEED_GRADE == 0) ? 65 : 70,
   parameter int T_DS_NS     = (SPEED_GRADE == 0) ? 30 : 35,
   parameter int T_WC_NS     = (SPEED_GRADE == 0) ? 70 : 85,
   parameter int T_DIS_NS    = 25
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic [AW-1:0] sram_addr,
   output logic          sram_cs_n,
   output logic          sram_we_n,
   output logic          sram_oe_n,
   output logic [DW-1:0] sram_dq_out,
   output logic          sram_dq_oe,
   input  logic [DW-1:0] sram_dq_in
);

   localparam int N_RD    = imax(ns_to_clk(T_ACC_NS, CLK_PS), ns_to_clk(T_OEACC_NS, CLK_PS));
   localparam int N_PULSE = imax(ns_to_clk(T_WP_NS, CLK_PS),
                                 imax(ns_to_clk(T_AW_NS, CLK_PS), ns_to_clk(T_DS_NS, CLK_PS)));
   localparam int N_REC   = imax(ns_to_clk(T_WC_NS, CLK_PS) - N_PULSE, 1);
   localparam int N_DIS   = ns_to_clk(T_DIS_NS, CLK_PS);
   localparam int N_MAX   = imax(imax(N_RD, N_PULSE), imax(N_REC, N_DIS));
   localparam int CW      = $clog2(N_MAX + 1);

   if (CLK_PS < 1)                         begin : g_bad_clk   $error("CLK_PS must be positive"); end
   if (SPEED_GRADE < 0 || SPEED_GRADE > 1) begin : g_bad_grade $error("SPEED_GRADE must be 0 or 1"); end
   if (AW < 1 || DW < 1)                   begin : g_bad_width $error("AW and DW must be positive"); end

   logic          phase_done, phase_load;
   logic [CW-1:0] phase_val;
   logic          turn_done, turn_load;
   logic [CW-1:0] turn_val;

   asram_down_cnt #(.W(CW)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (phase_load),
      .load_val (phase_val),
      .done     (phase_done)
   );

   // idle plus the turn state already cover two clocks of release time
   if (N_DIS > 2) begin : g_turn
      asram_down_cnt #(.W(CW)) u_turn (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (turn_load),
         .load_val (turn_val),
         .done     (turn_done)
      );
   end else begin : g_no_turn
      logic unused_turn;
      assign unused_turn = turn_load ^ (^turn_val);
      assign turn_done   = 1'b1;
   end

   asram_seq #(
      .AW(AW), .DW(DW), .CW(CW),
      .N_RD(N_RD), .N_PULSE(N_PULSE), .N_REC(N_REC), .N_DIS(N_DIS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .req_ready   (req_ready),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata),
      .phase_done  (phase_done),
      .phase_load  (phase_load),
      .phase_val   (phase_val),
      .turn_done   (turn_done),
      .turn_load   (turn_load),
      .turn_val    (turn_val),
      .sram_addr   (sram_addr),
      .sram_cs_n   (sram_cs_n),
      .sram_we_n   (sram_we_n),
      .sram_oe_n   (sram_oe_n),
      .sram_dq_out (sram_dq_out),
      .sram_dq_oe  (sram_dq_oe),
      .sram_dq_in  (sram_dq_in)
   );

endmodule

// File: tb/asram_cycle_ctrl_bench.sv
module asram_cycle_ctrl_bench;

   localparam int CLK_PS = 5000;

   function automatic int cyc(input int ns);
      return (ns * 1000 + CLK_PS - 1) / CLK_PS;
   endfunction

   localparam int E_ACC   = 14;  // ceil(70/5)
   localparam int E_RD    = 14;  // max(ceil(70/5), ceil(35/5))
   localparam int E_PULSE = 13;  // max(ceil(55/5), ceil(65/5), ceil(30/5))
   localparam int E_WC    = 14;  // ceil(70/5)
   localparam int E_DIS   = 5;   // ceil(25/5)

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [14:0] sram_addr;
   logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
   logic [7:0]  sram_dq_out;
   logic [7:0]  sram_dq_in = 8'h00;

   always #2.5ns clk = ~clk;

   asram_cycle_ctrl u_asram_cycle_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
      .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
      .sram_dq_in(sram_dq_in)
   );

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // memory model and expected data
   logic [7:0] mem [int];
   logic [7:0] ref_mem [int];
   logic [7:0] exp_q [$];
   int reads_issued = 0;
   int rsp_seen = 0;

   function automatic logic [7:0] mem_rd(input logic [14:0] a);
      return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
   endfunction

   function automatic logic [7:0] ref_rd(input logic [14:0] a);
      return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
   endfunction

   logic        p_cs = 1'b1, p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0, p_rsp = 1'b0;
   logic [14:0] p_addr = '0;
   logic [14:0] w_addr = '0;
   logic [7:0]  w_data = '0;
   int rd_age = 0, rd_len = 0, pw = 0, dq_ok = 0;
   int since_oe = 1000, wc = 1000;
   bit addr_ok = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         // R8: never drive against an enabled memory
         if (sram_dq_oe && !sram_oe_n) chk(0, "R8 drive during output enable", 1, 0);
         if (!sram_oe_n) since_oe = 0;
         else if (p_oe == 1'b0) since_oe = 1;
         else if (since_oe < 1000) since_oe++;
         if (sram_dq_oe && !p_dqoe)
            chk(since_oe > E_DIS, "R8 turnaround gap", since_oe - 1, E_DIS);

         // read model: wrong data until access time has passed
         if (!sram_cs_n && !sram_oe_n && sram_we_n && sram_addr == p_addr && rd_age > 0) rd_age++;
         else if (!sram_cs_n && !sram_oe_n && sram_we_n) rd_age = 1;
         else rd_age = 0;
         sram_dq_in <= (rd_age > E_ACC) ? mem_rd(sram_addr) : ~mem_rd(sram_addr);

         // R3 read window length
         if (!sram_oe_n) rd_len++;
         if (sram_oe_n && !p_oe) begin
            chk(rd_len == E_RD + 1, "R3 read window", rd_len, E_RD + 1);
            chk(rsp_valid == 1'b1, "R3 response after read", int'(rsp_valid), 1);
            rd_len = 0;
         end

         // R7 write cycle spacing
         if (!sram_cs_n && p_cs) chk(wc > E_WC, "R7 write cycle", wc - 1, E_WC);
         if (wc < 1000) wc++;

         // write pulse start
         if (!sram_we_n && p_we) begin
            chk(p_cs && !sram_cs_n, "R4 strobes fall together", int'(p_cs), 1);
            chk(sram_addr == p_addr, "R5 address setup", int'(sram_addr), int'(p_addr));
            pw = 0; dq_ok = 0; addr_ok = 1'b1; wc = 1; w_addr = sram_addr;
         end
         if (!sram_we_n) begin
            pw++;
            if (sram_dq_oe) dq_ok++;
            if (sram_addr != w_addr || !sram_oe_n) addr_ok = 1'b0;
            w_data = sram_dq_out;
         end
         if (sram_we_n && !p_we) begin
            chk(pw == E_PULSE, "R4 pulse length", pw, E_PULSE);
            chk(sram_cs_n == 1'b1, "R4 strobes rise together", int'(sram_cs_n), 1);
            chk(addr_ok, "R5 address stable, oe high in write", int'(addr_ok), 1);
            chk(dq_ok == pw, "R6 data driven whole pulse", dq_ok, pw);
            chk(!sram_dq_oe, "R6 drive released with strobes", int'(sram_dq_oe), 0);
            mem[int'(w_addr)] = w_data;
         end

         // R9 responses
         if (rsp_valid) begin
            rsp_seen++;
            chk(!p_rsp, "R9 response one cycle", int'(p_rsp), 0);
            if (exp_q.size() == 0) chk(0, "R9 unexpected response", 1, 0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(rsp_rdata == e, "R3 read data", int'(rsp_rdata), int'(e));
            end
         end

         p_cs = sram_cs_n; p_we = sram_we_n; p_oe = sram_oe_n;
         p_dqoe = sram_dq_oe; p_addr = sram_addr; p_rsp = rsp_valid;
      end
   end

   task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      if (w) ref_mem[int'(a)] = d;
      else begin
         exp_q.push_back(ref_rd(a));
         reads_issued++;
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R2 busy after accept", int'(req_ready), 0);
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         chk(0, "R2 watchdog expired", 0, 1);
         report();
      end
   end

   logic [14:0] pool [16];
   int pool_n = 0;

   initial begin
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes high in reset", int'(sram_cs_n & sram_we_n & sram_oe_n), 1);
      chk(!sram_dq_oe && !rsp_valid, "R1 no drive, no response", int'(sram_dq_oe | rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
      chk(sram_cs_n && sram_oe_n && sram_we_n, "R1 idle strobes", int'(sram_cs_n & sram_oe_n & sram_we_n), 1);

      // directed boundary addresses
      issue(1'b1, 15'h0000, 8'hA5);
      issue(1'b1, 15'h7FFF, 8'h5A);
      issue(1'b0, 15'h0000, 8'h00);
      issue(1'b0, 15'h7FFF, 8'h00);
      // read immediately followed by write: turnaround (R8)
      issue(1'b0, 15'h0000, 8'h00);
      issue(1'b1, 15'h1234, 8'h3C);
      issue(1'b0, 15'h1234, 8'h00);
      // back-to-back writes (R7)
      issue(1'b1, 15'h0001, 8'hFF);
      issue(1'b1, 15'h0002, 8'h00);
      issue(1'b0, 15'h0001, 8'h00);
      issue(1'b0, 15'h0002, 8'h00);

      // constrained random traffic
      for (int i = 0; i < 300; i++) begin
         if (pool_n < 4 || ($urandom % 2) == 0) begin
            logic [14:0] a;
            a = 15'($urandom);
            pool[pool_n % 16] = a;
            if (pool_n < 1000) pool_n++;
            issue(1'b1, a, 8'($urandom));
         end else begin
            int k;
            k = int'($urandom % 32'((pool_n < 16) ? pool_n : 16));
            issue(1'b0, pool[k], 8'h00);
         end
      end

      repeat (40) @(negedge clk);
      chk(rsp_seen == reads_issued, "R9 one response per read", rsp_seen, reads_issued);
      chk(exp_q.size() == 0, "R9 no missing responses", exp_q.size(), 0);
      chk(req_ready, "R2 idle at end", int'(req_ready), 1);
      finished = 1'b1;
      report();
   end

endmodule